// File: doc/BRIEF.md
# DC-Offset Removal High-Pass Stage with Offset Hold

This stage sits behind a decimation filter and takes 24-bit two's-complement samples for a left and a right channel. Each channel keeps its own running estimate of the DC level in a first-order leaky integrator. It subtracts that estimate from every sample, so the output has the DC content removed. The corner frequency is set by a shift amount. With the default shift of 13, the time constant is 8192 output samples, which places the corner near 1 Hz at a 48 kHz output rate. The corner scales in proportion to the sample rate.

A hold input stops the estimate from adapting, but the held value is still subtracted from each later sample. This supports a system offset calibration. The stage first runs unheld for roughly 10^5 samples, so the estimate can settle on the offset of the whole signal path. Then hold is raised, and that offset stays removed for as long as hold remains high. The difference is clamped to the 24-bit range and never wraps.

Top module: `dcrm_hpf`

## Requirements
- R1: After reset, `out_vld` is 0 and both outputs are 0. Both offset estimates are zero, so the first sample after reset appears on the output unchanged.
- R2: `out_vld` is high in exactly the cycle after each cycle in which `smp_vld` is high. The corrected samples are valid in that same cycle.
- R3: For each strobed sample x, the output is clamp(x - off). Here off is the integer part of the accumulator, meaning acc divided by 2^FRAC and rounded toward minus infinity. The value used is the one held before this sample's update.
- R4: On a strobe with `hold` low, the accumulator becomes acc + floor((x*2^FRAC - acc) / 2^K). The defaults are K = 13 and FRAC = 16.
- R5: On a strobe with `hold` high, the accumulator keeps its value, and the held offset is still subtracted from the sample.
- R6: The difference is clamped to the range -8388608 to 8388607.
- R7: The left and right channels have separate accumulators and do not affect each other.
- R8: In cycles without a strobe, the outputs and both accumulators keep their values, whatever the sample inputs are doing.
- R9: With a constant input held for 40000 strobes, the output magnitude falls below 1% of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | Sample strobe: one new left/right pair in this cycle |
| hold | input | 1 | High: hold the offset estimates, keep subtracting them |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_vld | output | 1 | Corrected pair valid |
| out_l | output | 24 | Corrected left sample |
| out_r | output | 24 | Corrected right sample |

## Verification
Two events can coincide in the same strobe cycle: the accumulator update (or its suppression by hold) and the subtraction. The subtraction must use the offset from before that strobe, while hold decides whether the accumulator moves on that same edge. The bench raises hold on a strobe in the middle of a stream and later drops it on a strobe. It compares every output against a model that updates only after computing the output. Clamping is also provoked while the offset is held, by driving the extreme codes against large held offsets of both signs.

// File: rtl/dcrm_pkg.sv
package dcrm_pkg;
  parameter int unsigned SMP_W      = 24;
  parameter int unsigned LEAK_SHIFT = 13;
  parameter int unsigned FRAC_W     = 16;
  parameter int unsigned N_CH       = 2;

  typedef enum logic [0:0] {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } ch_e;
endpackage

// File: rtl/dcrm_rst_sync.sv
module dcrm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_q_n = sync_q;
endmodule

// File: rtl/dcrm_acc.sv
module dcrm_acc #(
  parameter int unsigned DW   = dcrm_pkg::SMP_W,
  parameter int unsigned K    = dcrm_pkg::LEAK_SHIFT,
  parameter int unsigned FRAC = dcrm_pkg::FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 hold,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] off
);
  localparam int unsigned AW = DW + FRAC;

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_d;
  logic signed [AW-1:0] x_ext;
  logic signed [AW:0]   diff;
  logic signed [AW:0]   step;
  logic                 upd;

  assign upd = en && !hold;

  // next-state: leaky integration toward the scaled sample
  always_comb begin
    x_ext = {x, {FRAC{1'b0}}};
    diff  = {x_ext[AW-1], x_ext} - {acc_q[AW-1], acc_q};
    step  = diff >>> K;
    acc_d = acc_q + step[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (upd) begin
      acc_q <= acc_d;
    end
  end

  assign off = acc_q[AW-1:FRAC];
endmodule

// File: rtl/dcrm_sat_sub.sv
module dcrm_sat_sub #(
  parameter int unsigned DW = dcrm_pkg::SMP_W
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y
);
  localparam logic signed [DW-1:0] Y_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] Y_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0] d;

  always_comb begin
    d = {a[DW-1], a} - {b[DW-1], b};
    if (d[DW] != d[DW-1]) begin
      y = d[DW] ? Y_MIN : Y_MAX;
    end else begin
      y = d[DW-1:0];
    end
  end
endmodule

// File: rtl/dcrm_lane.sv
module dcrm_lane #(
  parameter int unsigned DW   = dcrm_pkg::SMP_W,
  parameter int unsigned K    = dcrm_pkg::LEAK_SHIFT,
  parameter int unsigned FRAC = dcrm_pkg::FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 hold,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y,
  output logic signed [DW-1:0] off
);
  logic signed [DW-1:0] y_d;
  logic signed [DW-1:0] y_q;

  dcrm_acc #(.DW(DW), .K(K), .FRAC(FRAC)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .hold (hold),
    .x    (x),
    .off  (off)
  );

  dcrm_sat_sub #(.DW(DW)) u_sub (
    .a(x),
    .b(off),
    .y(y_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (en) begin
      y_q <= y_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/dcrm_hpf.sv
module dcrm_hpf #(
  parameter int unsigned DW   = dcrm_pkg::SMP_W,
  parameter int unsigned K    = dcrm_pkg::LEAK_SHIFT,
  parameter int unsigned FRAC = dcrm_pkg::FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic                 hold,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);
  import dcrm_pkg::*;

  localparam int unsigned NCH = N_CH;

  logic                 rst_q_n;
  logic                 vld_q;
  logic signed [DW-1:0] x_arr   [NCH];
  logic signed [DW-1:0] y_arr   [NCH];
  logic signed [DW-1:0] off_arr [NCH];
  logic signed [DW-1:0] off_l;
  logic signed [DW-1:0] off_r;

  dcrm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  assign x_arr[CH_LEFT]  = in_l;
  assign x_arr[CH_RIGHT] = in_r;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    dcrm_lane #(.DW(DW), .K(K), .FRAC(FRAC)) u_lane (
      .clk  (clk),
      .rst_n(rst_q_n),
      .en   (smp_vld),
      .hold (hold),
      .x    (x_arr[c]),
      .y    (y_arr[c]),
      .off  (off_arr[c])
    );
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_vld;
    end
  end

  assign out_vld = vld_q;
  assign out_l   = y_arr[CH_LEFT];
  assign out_r   = y_arr[CH_RIGHT];
  assign off_l   = off_arr[CH_LEFT];
  assign off_r   = off_arr[CH_RIGHT];
endmodule

// File: rtl/dcrm_hpf_chk.sv
module dcrm_hpf_chk #(
  parameter int unsigned DW = dcrm_pkg::SMP_W
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 smp_vld,
  input logic                 hold,
  input logic signed [DW-1:0] in_l,
  input logic signed [DW-1:0] in_r,
  input logic                 out_vld,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic signed [DW-1:0] off_l,
  input logic signed [DW-1:0] off_r
);
  function automatic logic signed [DW-1:0] clampf(input logic signed [DW-1:0] a,
                                                  input logic signed [DW-1:0] b);
    logic signed [DW:0] d;
    d = {a[DW-1], a} - {b[DW-1], b};
    if (d > $signed({2'b00, {(DW-1){1'b1}}})) return {1'b0, {(DW-1){1'b1}}};
    if (d < $signed({2'b11, {(DW-1){1'b0}}})) return {1'b1, {(DW-1){1'b0}}};
    return d[DW-1:0];
  endfunction

  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld |=> out_vld);
  a_r2_vld_drops: assert property (@(posedge clk) disable iff (!rst_q_n)
    !smp_vld |=> !out_vld);
  a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    !smp_vld |=> ($stable(out_l) && $stable(out_r)));
  a_r8_off_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    !smp_vld |=> ($stable(off_l) && $stable(off_r)));
  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_q_n)
    (smp_vld && hold) |=> ($stable(off_l) && $stable(off_r)));
  a_r3_result_l: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld |=> (out_l == clampf($past(in_l), $past(off_l))));
  a_r3_result_r: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld |=> (out_r == clampf($past(in_r), $past(off_r))));
endmodule

bind dcrm_hpf dcrm_hpf_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_q_n(rst_q_n),
  .smp_vld(smp_vld),
  .hold   (hold),
  .in_l   (in_l),
  .in_r   (in_r),
  .out_vld(out_vld),
  .out_l  (out_l),
  .out_r  (out_r),
  .off_l  (off_l),
  .off_r  (off_r)
);

// File: tb/dcrm_hpf_bench.sv
`timescale 1ns/1ps
module dcrm_hpf_bench;
  localparam int DW   = 24;
  localparam int K    = 13;
  localparam int FRAC = 16;
  localparam longint YMAX = 8388607;
  localparam longint YMIN = -8388608;

  logic                 clk;
  logic                 rst_n;
  logic                 smp_vld;
  logic                 hold;
  logic signed [DW-1:0] in_l;
  logic signed [DW-1:0] in_r;
  logic                 out_vld;
  logic signed [DW-1:0] out_l;
  logic signed [DW-1:0] out_r;

  int     n_chk;
  int     n_bad;
  longint acc_l;
  longint acc_r;
  int     mism;
  longint last_act;
  longint last_exp;
  bit     done;

  dcrm_hpf #(.DW(DW), .K(K), .FRAC(FRAC)) u_dcrm_hpf (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .hold(hold),
    .in_l(in_l), .in_r(in_r), .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint sat(input longint v);
    if (v > YMAX) return YMAX;
    if (v < YMIN) return YMIN;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // one strobe; caller is at a falling edge
  task automatic step(input longint xl, input longint xr, input logic h);
    longint el, er;
    el = sat(xl - (acc_l >>> FRAC));
    er = sat(xr - (acc_r >>> FRAC));
    smp_vld = 1'b1; hold = h;
    in_l = xl[DW-1:0]; in_r = xr[DW-1:0];
    @(negedge clk);
    if (longint'(out_l) != el || longint'(out_r) != er || !out_vld) begin
      mism++;
      last_act = (longint'(out_l) != el) ? longint'(out_l) : longint'(out_r);
      last_exp = (longint'(out_l) != el) ? el : er;
    end
    if (!h) begin
      acc_l = acc_l + ((((xl <<< FRAC)) - acc_l) >>> K);
      acc_r = acc_r + ((((xr <<< FRAC)) - acc_r) >>> K);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      smp_vld = 1'b0;
      in_l = DW'(i * 7919 + 3);
      in_r = DW'(-i * 104729);
      hold = i[0];
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    smp_vld = 1'b0; hold = 1'b0; in_l = '0; in_r = '0;
    rst_n = 1'b0;
    acc_l = 0; acc_r = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    smp_vld = 1'b0; hold = 1'b0; in_l = '0; in_r = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_vld in reset", longint'(out_vld), 0);
    check("R1 out_l in reset", longint'(out_l), 0);
    check("R1 out_r in reset", longint'(out_r), 0);
    rst_n = 1'b1;
    acc_l = 0; acc_r = 0;
    repeat (3) @(negedge clk);
    step(1234, -4321, 1'b0);
    check("R1 first left sample unchanged", longint'(out_l), 1234);
    check("R1 first right sample unchanged", longint'(out_r), -4321);
  endtask

  task automatic t_strobe_timing();
    longint hl, hr;
    check("R2 out_vld after strobe", longint'(out_vld), 1);
    hl = longint'(out_l); hr = longint'(out_r);
    idle(1);
    check("R2 out_vld low without strobe", longint'(out_vld), 0);
    idle(5);
    check("R8 left output held while idle", longint'(out_l), hl);
    check("R8 right output held while idle", longint'(out_r), hr);
    mism = 0;
    step(77, -77, 1'b0);
    smp_vld = 1'b0;
    check("R8 accumulator untouched by idle inputs", mism, 0);
  endtask

  task automatic t_decay();
    mism = 0;
    for (int i = 0; i < 40000; i++) step(100000, -50000, 1'b0);
    smp_vld = 1'b0;
    if (mism != 0) check("R4 decay trace vs model", last_act, last_exp);
    else check("R4 decay trace vs model", 0, 0);
    check("R9 left residue below 1%", longint'(out_l > -1000 && out_l < 1000), 1);
    check("R9 right residue below 1%", longint'(out_r > -500 && out_r < 500), 1);
    check("R7 channels follow separate estimates", longint'(out_l != out_r), 1);
  endtask

  task automatic t_hold();
    longint hl;
    mism = 0;
    hl = acc_l >>> FRAC;
    for (int i = 0; i < 50; i++) step(100000 + i * 40, -50000, 1'b0);
    // hold raised on a strobe in mid-stream
    step(100000 + 3000, -50000 - 3000, 1'b1);
    hl = acc_l >>> FRAC;
    for (int i = 0; i < 300; i++) begin
      step(100000 + (i % 17) * 5000 - 40000, -60000 + i * 3, 1'b1);
      check_exact_hold(hl, 100000 + (i % 17) * 5000 - 40000, i);
    end
    // hold dropped on a strobe
    step(250000, 250000, 1'b0);
    step(250000, 250000, 1'b0);
    smp_vld = 1'b0;
    if (mism != 0) check("R5 hold/strobe coincidence vs model", last_act, last_exp);
    else check("R5 hold/strobe coincidence vs model", 0, 0);
  endtask

  task automatic check_exact_hold(input longint hl, input longint x, input int i);
    if (i == 299) check("R5 held offset subtracted exactly", longint'(out_l), x - hl);
  endtask

  task automatic t_sat();
    longint ol, orr;
    for (int i = 0; i < 20000; i++) step(3000000, -3000000, 1'b0);
    ol = acc_l >>> FRAC; orr = acc_r >>> FRAC;
    check("R3 left offset large positive in model", longint'(ol > 2000000), 1);
    step(YMIN, YMAX, 1'b1);
    check("R6 clamp to minimum", longint'(out_l), YMIN);
    check("R6 clamp to maximum", longint'(out_r), YMAX);
    step(-100, 100, 1'b1);
    check("R3 in-range difference left", longint'(out_l), -100 - ol);
    check("R3 in-range difference right", longint'(out_r), 100 - orr);
    smp_vld = 1'b0;
  endtask

  task automatic t_rereset();
    do_reset();
    check("R1 outputs cleared by reset", longint'(out_l), 0);
    step(-555, 999, 1'b0);
    smp_vld = 1'b0;
    check("R1 estimate cleared by reset", longint'(out_l), -555);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    t_reset();
    t_strobe_timing();
    t_decay();
    t_hold();
    t_sat();
    t_rereset();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule